// File: doc/BRIEF.md
# SPI Master Controller

This block is a memory-mapped SPI master that moves one word per transfer. Software fills a control word with the serial clock polarity and phase, the bit order, an internal loopback switch, the word length and a two-stage clock divisor. It then writes a data word into the transmit slot. The engine shifts that word out on `mosi` and samples `miso` on the opposite class of `sck` edge. When the word is done, it posts the received bits and raises a receive-ready flag.

Two flags record progress: receive-ready and transmit-free. Each flag can be cleared independently by writing a one to it. A mask word selects which flags drive the `irq` line. Chip selects sit outside the block. The datapath holds one word in each direction and no more.

Registers are 32 bits wide. Reads are combinational on `regAddr`. Writes take effect on the rising clock edge at which `regWrEn` is high. The byte offsets are:

- 0x20: control
- 0x24: flags
- 0x28: flag mask
- 0x2C: command, which reads zero and has no effect
- 0x30: transmit
- 0x34: receive

Top module: `spim_master`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `sck` is 0.
- R2: Control word fields are at these bit positions: 30 loopback, 29 clock idle high, 28 late-sample phase, 27 slow divisor, 26 MSB first, 25 master select, 24 enable, 23:20 length code, 19:16 prescaler. All other bits read zero. While enable reads 1, a control write changes only the enable bit and leaves every other field unchanged.
- R3: With prescaler value P, one half period of `sck` lasts 2·(P+1) clocks, or 32·(P+1) clocks when bit 27 is set. A word of L bits completes exactly 2·L half periods after the clock edge that accepted the transmit write.
- R4: A length code of 0 gives L = 32; any other code c gives L = c+1. A transfer makes exactly 2·L `sck` transitions, and `sck` rests at the level of bit 29 whenever no transfer is running.
- R5: With bit 28 clear, `miso` is sampled on the first edge of each bit period and `mosi` changes on the second edge. With bit 28 set, `mosi` changes on the first edge and `miso` is sampled on the second edge.
- R6: With bit 26 set, bit L-1 of the transmit word goes out first. With bit 26 clear, bit 0 goes out first. The received bits are assembled in the same order.
- R7: With bit 30 set, the outgoing bits are fed back as the input and `miso` is ignored. The received word then equals the transmitted word truncated to L bits.
- R8: The receive register holds the last completed word right-justified, and every bit at position L or above is zero.
- R9: Flag bit 9 (receive-ready) sets when a word completes. Flag bit 8 (transmit-free) clears when a transfer starts and sets when it completes or is aborted. Writing a one to either bit clears it. A flag being set in the same cycle wins over a clear.
- R10: `irq` is high exactly when some flag bit (9 or 8) is set together with the mask bit at the same position.
- R11: A transmit write is ignored while enable is 0 or while a transfer is running.
- R12: Clearing enable during a transfer aborts it. `sck` returns to its idle level one clock later, receive-ready is not set, and transmit-free is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on `regAddr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The results of a register write become visible on the next read half a clock later, and `irq` follows at the same time because it is combinational on the stored flags.

For a transfer of L bits with a half period of H clocks, receive-ready and the receive word change on the edge that comes exactly 2·L·H clocks after the edge that accepted the transmit write. The bench therefore reads the flags one cycle before that edge, where it expects receive-ready and transmit-free both low, and again just after it, where it expects both high. This catches any prescaler or edge-count slip.

An abort is checked one clock after the disabling write lands. A stalled transfer is checked by counting `sck` transitions over a long idle window.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int LEN_W   = 4;
  localparam int PM_W    = 4;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int LENV_W  = IDX_W + 1;
  localparam int FAST_SH = 1;
  localparam int SLOW_SH = 5;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EVENT = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TX    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_RX    = 8'h34;

  localparam int B_LOOP   = 30;
  localparam int B_CPOL   = 29;
  localparam int B_CPHA   = 28;
  localparam int B_DIV16  = 27;
  localparam int B_MSB    = 26;
  localparam int B_MASTER = 25;
  localparam int B_EN     = 24;
  localparam int B_LEN    = 20;
  localparam int B_PM     = 16;
  localparam int B_NE     = 9;
  localparam int B_NF     = 8;

  typedef struct packed {
    logic loop;
    logic cpol;
    logic cpha;
    logic div16;
    logic msbFirst;
    logic master;
    logic enable;
    logic [LEN_W-1:0] lenCode;
    logic [PM_W-1:0] pm;
  } spimCfg_t;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sample;
    logic done;
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [B_LOOP:B_PM]     modeWr,
  input  logic [B_NE:B_NF]       flagWr,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [DATA_W-1:0]      rxWord,
  output spimStrobe_t            stb,
  output logic [LENV_W-1:0]      wordLen,
  output logic                   cfgMsb,
  output logic                   cfgLoop,
  output logic                   sck,
  output logic                   irq
);
  localparam int HALF_W = PM_W + 1 + SLOW_SH;
  localparam int EDGE_W = LENV_W + 1;

  spimCfg_t cfg;
  logic busy, phase, evNe, evNf, mkNe, mkNf;
  logic [HALF_W-1:0] halfCnt, pmPlus, halfLim;
  logic [EDGE_W-1:0] edgeCnt, edgeLast;
  logic wrMode, wrEvent, wrMask, wrTx;
  logic start, abort, tick, leading, lastEdge;

  assign wrMode  = regWrEn && (regAddr == OFS_MODE);
  assign wrEvent = regWrEn && (regAddr == OFS_EVENT);
  assign wrMask  = regWrEn && (regAddr == OFS_MASK);
  assign wrTx    = regWrEn && (regAddr == OFS_TX);

  // Control word: fields are frozen while the enable bit reads 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrMode) begin
      cfg.enable <= modeWr[B_EN];
      if (!cfg.enable) begin
        cfg.loop     <= modeWr[B_LOOP];
        cfg.cpol     <= modeWr[B_CPOL];
        cfg.cpha     <= modeWr[B_CPHA];
        cfg.div16    <= modeWr[B_DIV16];
        cfg.msbFirst <= modeWr[B_MSB];
        cfg.master   <= modeWr[B_MASTER];
        cfg.lenCode  <= modeWr[B_LEN +: LEN_W];
        cfg.pm       <= modeWr[B_PM +: PM_W];
      end
    end
  end

  assign wordLen  = (cfg.lenCode == '0) ? LENV_W'(DATA_W)
                                        : LENV_W'(cfg.lenCode) + LENV_W'(1);
  assign edgeLast = EDGE_W'({wordLen, 1'b0}) - EDGE_W'(1);
  assign pmPlus   = HALF_W'(cfg.pm) + HALF_W'(1);
  assign halfLim  = cfg.div16 ? (pmPlus << SLOW_SH) : (pmPlus << FAST_SH);

  assign start    = wrTx && cfg.enable && !busy;
  assign abort    = busy && !cfg.enable;
  assign tick     = busy && !abort && (halfCnt == halfLim - HALF_W'(1));
  assign leading  = !edgeCnt[0];
  assign lastEdge = tick && (edgeCnt == edgeLast);

  assign stb.load     = start;
  assign stb.sample   = tick && (cfg.cpha ? !leading : leading);
  assign stb.shiftOut = tick && (cfg.cpha ? (leading && edgeCnt != '0) : !leading);
  assign stb.done     = lastEdge;

  always_ff @(posedge clk) begin
    if (!rstN || abort || start) begin
      busy    <= rstN && start;
      phase   <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        halfCnt <= '0;
        phase   <= ~phase;
        edgeCnt <= edgeCnt + EDGE_W'(1);
        if (lastEdge) busy <= 1'b0;
      end else begin
        halfCnt <= halfCnt + HALF_W'(1);
      end
    end
  end

  assign sck = cfg.cpol ^ (busy & phase);

  // Flags: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evNe <= 1'b0;
      evNf <= 1'b0;
      mkNe <= 1'b0;
      mkNf <= 1'b0;
    end else begin
      if (stb.done) evNe <= 1'b1;
      else if (wrEvent && flagWr[B_NE]) evNe <= 1'b0;
      if (stb.done || abort) evNf <= 1'b1;
      else if (start) evNf <= 1'b0;
      else if (wrEvent && flagWr[B_NF]) evNf <= 1'b0;
      if (wrMask) begin
        mkNe <= flagWr[B_NE];
        mkNf <= flagWr[B_NF];
      end
    end
  end

  assign irq     = (evNe & mkNe) | (evNf & mkNf);
  assign cfgMsb  = cfg.msbFirst;
  assign cfgLoop = cfg.loop;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MODE: begin
        regRdData[B_LOOP]   = cfg.loop;
        regRdData[B_CPOL]   = cfg.cpol;
        regRdData[B_CPHA]   = cfg.cpha;
        regRdData[B_DIV16]  = cfg.div16;
        regRdData[B_MSB]    = cfg.msbFirst;
        regRdData[B_MASTER] = cfg.master;
        regRdData[B_EN]     = cfg.enable;
        regRdData[B_LEN +: LEN_W] = cfg.lenCode;
        regRdData[B_PM +: PM_W]   = cfg.pm;
      end
      OFS_EVENT: begin
        regRdData[B_NE] = evNe;
        regRdData[B_NF] = evNf;
      end
      OFS_MASK: begin
        regRdData[B_NE] = mkNe;
        regRdData[B_NF] = mkNf;
      end
      OFS_RX:  regRdData = rxWord;
      default: regRdData = '0;
    endcase
  end

  p_ne_on_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> evNe);
  p_nf_low_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (busy && !evNf));
  p_abort_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && (sck == cfg.cpol)));
  p_fields_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfg.enable) |=> $stable({cfg.loop, cfg.cpol, cfg.cpha, cfg.div16,
                                      cfg.msbFirst, cfg.lenCode, cfg.pm}));
  p_even_edges_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |-> edgeCnt[0]);
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       stb,
  input  logic [DATA_W-1:0] txWord,
  input  logic [LENV_W-1:0] wordLen,
  input  logic              msbFirst,
  input  logic              loopBack,
  input  logic              misoIn,
  output logic              mosiOut,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txShift, rxShift, rxNext;
  logic [IDX_W-1:0]  lastIdx;
  logic              inBit;

  assign lastIdx = IDX_W'(wordLen - LENV_W'(1));
  assign mosiOut = msbFirst ? txShift[lastIdx] : txShift[0];
  assign inBit   = loopBack ? mosiOut : misoIn;
  assign rxNext  = msbFirst ? {rxShift[DATA_W-2:0], inBit}
                            : ((rxShift >> 1) | (DATA_W'(inBit) << lastIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (stb.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end else begin
        if (stb.shiftOut) txShift <= msbFirst ? (txShift << 1) : (txShift >> 1);
        if (stb.sample)   rxShift <= rxNext;
      end
      if (stb.done) rxWord <= stb.sample ? rxNext : rxShift;
    end
  end

  p_rx_justified_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> ((rxWord >> $past(wordLen)) == '0));
  p_edge_roles_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.sample && stb.shiftOut));
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  spimStrobe_t       stb;
  logic [LENV_W-1:0] wordLen;
  logic [DATA_W-1:0] rxWord;
  logic              cfgMsb, cfgLoop;

  spim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .modeWr(regWrData[B_LOOP:B_PM]), .flagWr(regWrData[B_NE:B_NF]),
    .regRdData(regRdData), .rxWord(rxWord), .stb(stb), .wordLen(wordLen),
    .cfgMsb(cfgMsb), .cfgLoop(cfgLoop), .sck(sck), .irq(irq)
  );

  spim_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(regWrData), .wordLen(wordLen),
    .msbFirst(cfgMsb), .loopBack(cfgLoop), .misoIn(miso), .mosiOut(mosi),
    .rxWord(rxWord)
  );
endmodule

// File: tb/spim_master_test.sv
module spim_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sck, mosi, miso, irq;

  int nChk = 0;
  int nBad = 0;
  int edgeSeen = 0;
  int tbL = 8;
  logic tbMsb = 1'b1;
  logic tbCpha = 1'b0;
  logic [31:0] slvWord = '0;

  always #4 clk = ~clk;

  spim_master uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  always @(sck) edgeSeen = edgeSeen + 1;

  function automatic logic slvBit(int e, int len, logic msb, logic cp, logic [31:0] w);
    int i;
    if (e < int'(cp)) return 1'b0;
    i = (e - int'(cp)) / 2;
    if (i >= len) return 1'b0;
    return msb ? w[len-1-i] : w[i];
  endfunction

  assign miso = slvBit(edgeSeen, tbL, tbMsb, tbCpha, slvWord);

  typedef struct packed {
    logic cpol, cpha, msb, loop, div16;
    logic [3:0] pm, lenF;
    logic [31:0] tx, slv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,4'd7, 32'h0000_00A5,32'h0000_003C},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'd1,4'd7, 32'h0000_005A,32'h0000_00C3},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd11,32'h0000_0ABC,32'h0000_05E1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd2,4'd3, 32'h0000_0009,32'h0000_0006},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,4'd0,4'd15,32'h0000_BEEF,32'h0000_1234},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd0, 32'hDEAD_BEEF,32'h1357_9BDF},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'd0,4'd7, 32'hFF00_FF81,32'hFFFF_FF7E},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3,4'd8, 32'hFFFF_F1A7,32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h00; regWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 8'h00;
  endtask

  function automatic logic [31:0] mw(input vec_t t, input logic en);
    logic [31:0] w;
    w = '0;
    w[30] = t.loop; w[29] = t.cpol; w[28] = t.cpha; w[27] = t.div16;
    w[26] = t.msb; w[25] = 1'b1; w[24] = en;
    w[23:20] = t.lenF; w[19:16] = t.pm;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d, w1;
    vec_t t, tq;
    int L, hl, n, e1;
    logic [31:0] msk, expRx;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h20, d); chk("R1 mode", d, 32'h0);
    rd(8'h24, d); chk("R1 event", d, 32'h0);
    rd(8'h28, d); chk("R1 mask", d, 32'h0);
    rd(8'h2C, d); chk("R1 cmd", d, 32'h0);
    rd(8'h30, d); chk("R1 tx", d, 32'h0);
    rd(8'h34, d); chk("R1 rx", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 sck", {31'b0, sck}, 32'h0);

    // R2 field placement and freeze while enabled
    w1 = 32'h7C5A_0000;
    wr(8'h20, w1 | 32'h8000_0000); rd(8'h20, d); chk("R2 fields", d, w1);
    wr(8'h20, w1 | 32'h0100_0000); rd(8'h20, d); chk("R2 enable", d, w1 | 32'h0100_0000);
    wr(8'h20, 32'h0100_0000);      rd(8'h20, d); chk("R2 frozen", d, w1 | 32'h0100_0000);
    wr(8'h20, 32'h0);              rd(8'h20, d); chk("R2 disable keeps", d, w1);
    wr(8'h20, 32'h0);              rd(8'h20, d); chk("R2 cleared", d, 32'h0);

    // Table of transfers: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      t   = VECS[v];
      L   = (t.lenF == 4'd0) ? 32 : int'(t.lenF) + 1;
      hl  = t.div16 ? 32 * (int'(t.pm) + 1) : 2 * (int'(t.pm) + 1);
      n   = 2 * L * hl;
      msk = (L == 32) ? 32'hFFFF_FFFF : ((32'h1 << L) - 32'h1);
      expRx = t.loop ? (t.tx & msk) : (t.slv & msk);
      wr(8'h20, 32'h0);
      wr(8'h20, mw(t, 1'b1));
      wr(8'h24, 32'h0000_0300);
      tbL = L; tbMsb = t.msb; tbCpha = t.cpha; slvWord = t.slv;
      chk($sformatf("R4 idle level v%0d", v), {31'b0, sck}, {31'b0, t.cpol});
      edgeSeen = 0;
      wr(8'h30, t.tx);
      repeat (n - 1) @(negedge clk);
      rd(8'h24, d); chk($sformatf("R3 R9 before done v%0d", v), d, 32'h0);
      @(negedge clk);
      rd(8'h24, d); chk($sformatf("R3 R9 at done v%0d", v), d, 32'h0000_0300);
      rd(8'h34, d); chk($sformatf("R5 R6 R7 R8 rx v%0d", v), d, expRx);
      chk($sformatf("R4 edge count v%0d", v), edgeSeen, 2 * L);
      chk($sformatf("R4 rest level v%0d", v), {31'b0, sck}, {31'b0, t.cpol});
    end

    // R11 transmit write while disabled is ignored
    tq = '{1'b0,1'b0,1'b1,1'b1,1'b0,4'd0,4'd7,32'h0000_00A5,32'h0};
    wr(8'h20, 32'h0);
    wr(8'h20, mw(tq, 1'b0));
    wr(8'h24, 32'h0000_0300);
    edgeSeen = 0;
    wr(8'h30, 32'h0000_0055);
    repeat (100) @(negedge clk);
    chk("R11 disabled no edges", edgeSeen, 0);
    rd(8'h24, d); chk("R11 disabled no flags", d, 32'h0);

    // R11 transmit write while busy is ignored (loopback, 8 bits, H=2)
    wr(8'h20, mw(tq, 1'b1));
    edgeSeen = 0;
    wr(8'h30, 32'h0000_00A5);
    wr(8'h30, 32'h0000_003C);
    repeat (32 - 3) @(negedge clk);
    rd(8'h24, d); chk("R11 busy before done", d, 32'h0);
    @(negedge clk);
    rd(8'h24, d); chk("R11 busy at done", d, 32'h0000_0300);
    rd(8'h34, d); chk("R11 first word kept", d, 32'h0000_00A5);
    chk("R11 single transfer edges", edgeSeen, 16);

    // R10 interrupt = flag AND mask
    wr(8'h28, 32'h0);          chk("R10 none masked", {31'b0, irq}, 32'h0);
    wr(8'h28, 32'h0000_0200);  chk("R10 ne masked", {31'b0, irq}, 32'h1);
    wr(8'h24, 32'h0000_0200);  chk("R10 ne cleared", {31'b0, irq}, 32'h0);
    rd(8'h24, d);              chk("R9 w1c only ne", d, 32'h0000_0100);
    wr(8'h28, 32'h0000_0100);  chk("R10 nf masked", {31'b0, irq}, 32'h1);
    rd(8'h28, d);              chk("R10 mask readback", d, 32'h0000_0100);
    wr(8'h24, 32'h0000_0100);  chk("R10 nf cleared", {31'b0, irq}, 32'h0);
    wr(8'h28, 32'h0);

    // R12 abort mid-transfer (cpol=1, P=3 so H=8)
    tq = '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd3,4'd7,32'h0000_00F0,32'h0000_0055};
    wr(8'h20, 32'h0);
    wr(8'h20, mw(tq, 1'b1));
    wr(8'h24, 32'h0000_0300);
    tbL = 8; tbMsb = 1'b1; tbCpha = 1'b0; slvWord = tq.slv;
    edgeSeen = 0;
    wr(8'h30, tq.tx);
    repeat (20) @(negedge clk);
    rd(8'h24, d); chk("R9 nf low while busy", d, 32'h0);
    wr(8'h20, mw(tq, 1'b0));
    @(negedge clk);
    chk("R12 sck idle after abort", {31'b0, sck}, 32'h1);
    rd(8'h24, d); chk("R12 flags after abort", d, 32'h0000_0100);
    e1 = edgeSeen;
    repeat (200) @(negedge clk);
    chk("R12 no further edges", edgeSeen, e1);
    rd(8'h24, d); chk("R12 no ne later", d, 32'h0000_0100);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule